// File: doc/BRIEF.md
# Port-Mapped SPI Byte Bridge for an 8-bit Expansion Bus

This block is an 8-bit expansion-bus I/O slave that gives the host a byte-wide path to an SPI device such as a memory card. It answers an eight-byte I/O window and uses two offsets in it. Offset 0 is the data port and offset 1 is the select port. A write to the data port transmits the written byte. A read of the data port transmits an all-ones byte and returns whatever the device shifted back. A write to the select port sets the level of the active-low chip select.

Each data-port access runs a complete eight-bit exchange inside the host bus cycle. The block pulls the bus ready line low so the host inserts wait states until the byte is done, so the host never polls and nothing is buffered. The bus strobes are synchronised into the block clock, and each access is acted on once, at the strobe's falling edge. The SPI clock runs at a rate set by a parameterised divider of the system clock.

Top module: `isa_spi_bridge`

## Requirements
- R1: An access whose address ANDed with 12'hFF8 differs from BASE_ADDR ANDed with 12'hFF8 is ignored: no SCLK pulse, no change of chip select, io_rdy stays high and the data bus is not driven.
- R2: A write to offset 0 transmits the written byte on MOSI, most-significant bit first, with exactly eight SCLK pulses.
- R3: A read from offset 0 transmits 8'hFF and, once io_rdy returns high, presents on data_out the eight MISO bits sampled in the order received, the first one landing in bit 7.
- R4: A write to offset 1 copies data bit 0 into cs_n. cs_n keeps its level across later byte transfers until the next offset-1 write.
- R5: After reset sclk=0, mosi=0, cs_n=1, io_rdy=1 and data_oe=0.
- R6: Every bit takes three phases of DIV clocks each: SCLK low with the MOSI bit shown, SCLK high with MISO sampled at the rising edge, then SCLK and MOSI both low. SCLK is high for 8*DIV clocks per byte, and MOSI is high for 2*DIV clocks per one bit sent.
- R7: io_rdy is low for exactly 24*DIV+1 clocks on a data read, and for SETTLE_CLKS+24*DIV+1 clocks on a data write, and it covers every SCLK pulse of that byte.
- R8: Write data is captured SETTLE_CLKS clocks after the synchronised write strobe falls. A later change of data_in during the same access is not transmitted.
- R9: After an access the block waits until both strobes are high again. A strobe that is held low after io_rdy returns does not start a second exchange.
- R10: data_oe is high only while ior_n is low and the address is in the window. Offset 0 returns the last received byte, and every other offset returns 8'hFF.
- R11: Reads of offsets 1 to 7 and writes to offsets 2 to 7 cause no SPI activity and leave cs_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 12 | Bus I/O address |
| iow_n | input | 1 | I/O write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data toward the bus |
| data_oe | output | 1 | Drive enable for data_out; the bus is released when low |
| io_rdy | output | 1 | Bus ready; low stretches the host cycle |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data toward the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
On every cycle, the assertions check these rules: SCLK and MOSI rest low outside a transfer, MOSI holds steady while SCLK stays high, io_rdy stays low whenever the shift engine is busy, and chip select cannot move during a byte. They also check that an exchange only starts when the engine is idle, that the hold state lasts until both strobes are high, and that the bus is driven only while the read strobe is low. The directed scenarios cover the rest: the byte that actually appears on MOSI and its bit order, the value returned from MISO, the exact ready-low and SCLK-high cycle counts, the point at which write data is captured, and the window decode with its ignored offsets.

// File: rtl/isa_spi_pkg.sv
package isa_spi_pkg;

  localparam int unsigned IO_ADDR_W = 12;
  localparam int unsigned WIN_BITS  = 3;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SETTLE,
    BUS_XFER,
    BUS_HOLD
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_HIGH,
    PH_TAIL
  } spi_phase_e;

  // True when the address falls in the eight-byte window at base.
  function automatic logic win_hit(input logic [IO_ADDR_W-1:0] a,
                                   input logic [IO_ADDR_W-1:0] base);
    logic [IO_ADDR_W-1:0] m;
    m = {{(IO_ADDR_W-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};
    return (a & m) == (base & m);
  endfunction

  function automatic logic [WIN_BITS-1:0] win_offset(input logic [IO_ADDR_W-1:0] a);
    return a[WIN_BITS-1:0];
  endfunction

  // Clocks taken by one byte exchange: three phases per bit.
  function automatic int unsigned xfer_clocks(input int unsigned div,
                                              input int unsigned bits);
    return 3 * div * bits;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_sync
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= raw_n[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl_n[i] = s2;
    assign fall[i]  = s3 & ~s2;
  end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import isa_spi_pkg::*;
#(
  parameter int unsigned DIV = 2,
  parameter int unsigned W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx,
  output logic         sclk,
  output logic         mosi
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);
  localparam logic [BW-1:0] B_LAST = BW'(W - 1);

  spi_phase_e   phase;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  sh_tx;
  logic          step;

  assign step = busy && (cnt == C_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= PH_LEAD;
      cnt     <= '0;
      bit_idx <= '0;
      sh_tx   <= '0;
      rx      <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        phase   <= PH_LEAD;
        cnt     <= '0;
        bit_idx <= '0;
        sh_tx   <= tx;
      end else if (busy) begin
        if (step) begin
          cnt <= '0;
          unique case (phase)
            PH_LEAD: begin
              phase <= PH_HIGH;
              rx    <= {rx[W-2:0], miso};
            end
            PH_HIGH: phase <= PH_TAIL;
            default: begin
              if (bit_idx == B_LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                sh_tx   <= {sh_tx[W-2:0], 1'b0};
              end
              phase <= PH_LEAD;
            end
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sclk = busy && (phase == PH_HIGH);
  assign mosi = busy && (phase != PH_TAIL) && sh_tx[W-1];

endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import isa_spi_pkg::*;
#(
  parameter logic [IO_ADDR_W-1:0] BASE_ADDR   = 12'h378,
  parameter int unsigned          SETTLE_CLKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IO_ADDR_W-1:0] addr,
  input  logic [7:0]           din,
  input  logic                 rd_fall,
  input  logic                 wr_fall,
  input  logic                 strobes_idle,
  input  logic                 eng_done,
  output logic                 start,
  output logic [7:0]           tx,
  output logic                 cs_n,
  output logic                 rdy,
  output logic                 hold
);

  localparam int unsigned SW = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CLKS - 1);

  bus_state_e          st;
  logic [SW-1:0]       cnt;
  logic [WIN_BITS-1:0] off_q;
  logic                hit;
  logic [WIN_BITS-1:0] off;
  logic                settle_end;

  assign hit        = win_hit(addr, BASE_ADDR);
  assign off        = win_offset(addr);
  assign settle_end = (st == BUS_SETTLE) && (cnt == S_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= BUS_IDLE;
      cnt   <= '0;
      off_q <= '0;
      cs_n  <= 1'b1;
    end else begin
      unique case (st)
        BUS_IDLE: begin
          if (rd_fall && hit) begin
            st <= (off == '0) ? BUS_XFER : BUS_HOLD;
          end else if (wr_fall && hit) begin
            st    <= BUS_SETTLE;
            off_q <= off;
            cnt   <= '0;
          end
        end
        BUS_SETTLE: begin
          if (cnt == S_LAST) begin
            if (off_q == '0) begin
              st <= BUS_XFER;
            end else begin
              if (off_q == WIN_BITS'(1)) cs_n <= din[0];
              st <= BUS_HOLD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BUS_XFER: if (eng_done) st <= BUS_HOLD;
        default:  if (strobes_idle) st <= BUS_IDLE;
      endcase
    end
  end

  assign start = ((st == BUS_IDLE) && rd_fall && hit && (off == '0)) ||
                 (settle_end && (off_q == '0));
  assign tx    = (st == BUS_SETTLE) ? din : 8'hFF;
  assign rdy   = !((st == BUS_SETTLE) || (st == BUS_XFER));
  assign hold  = (st == BUS_HOLD);

endmodule

// File: rtl/isa_spi_bridge.sv
module isa_spi_bridge
  import isa_spi_pkg::*;
#(
  parameter logic [11:0] BASE_ADDR   = 12'h378,
  parameter int unsigned DIV         = 2,
  parameter int unsigned SETTLE_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] io_addr,
  input  logic        iow_n,
  input  logic        ior_n,
  input  logic [7:0]  data_in,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic        io_rdy,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);

  logic [1:0] lvl_n, fall;
  logic       strobes_idle;
  logic       eng_start, eng_busy, eng_done;
  logic [7:0] eng_tx, eng_rx;
  logic       fsm_hold;
  logic [7:0] rd_q;

  strobe_sync #(.N(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_n ({iow_n, ior_n}),
    .lvl_n (lvl_n),
    .fall  (fall)
  );

  assign strobes_idle = &lvl_n;

  bus_ctrl #(.BASE_ADDR(BASE_ADDR), .SETTLE_CLKS(SETTLE_CLKS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (io_addr),
    .din          (data_in),
    .rd_fall      (fall[0]),
    .wr_fall      (fall[1]),
    .strobes_idle (strobes_idle),
    .eng_done     (eng_done),
    .start        (eng_start),
    .tx           (eng_tx),
    .cs_n         (cs_n),
    .rdy          (io_rdy),
    .hold         (fsm_hold)
  );

  spi_byte_engine #(.DIV(DIV), .W(8)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .tx    (eng_tx),
    .miso  (miso),
    .busy  (eng_busy),
    .done  (eng_done),
    .rx    (eng_rx),
    .sclk  (sclk),
    .mosi  (mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_q <= 8'hFF;
    else if (eng_done) rd_q <= eng_rx;
  end

  assign data_oe  = !ior_n && win_hit(io_addr, BASE_ADDR);
  assign data_out = (win_offset(io_addr) == '0) ? rd_q : 8'hFF;

endmodule

// File: rtl/isa_spi_bridge_chk.sv
module isa_spi_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic ior_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic io_rdy,
  input logic data_oe,
  input logic eng_busy,
  input logic eng_start,
  input logic fsm_hold,
  input logic strobes_idle
);

  p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (!sclk && !mosi));

  p_mosi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_wait_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !io_rdy);

  p_start_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);

  p_cs_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> $stable(cs_n));

  p_hold_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_hold && !strobes_idle) |=> fsm_hold);

  p_drive_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !ior_n);

endmodule

bind isa_spi_bridge isa_spi_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ior_n        (ior_n),
  .sclk         (sclk),
  .mosi         (mosi),
  .cs_n         (cs_n),
  .io_rdy       (io_rdy),
  .data_oe      (data_oe),
  .eng_busy     (eng_busy),
  .eng_start    (eng_start),
  .fsm_hold     (fsm_hold),
  .strobes_idle (strobes_idle)
);

// File: tb/tb_isa_spi_bridge.sv
module tb_isa_spi_bridge;

  localparam int DIV    = 2;
  localparam int SETTLE = 3;
  localparam int WIN    = 3 * 8 * DIV + SETTLE + 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] io_addr = 12'h000;
  logic       iow_n = 1'b1;
  logic       ior_n = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_oe, io_rdy, sclk, mosi, miso, cs_n;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // Bench-side SPI device
  logic [7:0] slave_byte = 8'h00;
  logic [2:0] slv_idx = 3'd0;
  logic [7:0] mon_byte = 8'h00;
  int         pulses = 0;

  always #10 clk = ~clk;

  assign miso = slave_byte[~slv_idx];
  always @(posedge sclk) begin
    mon_byte <= {mon_byte[6:0], mosi};
    pulses   <= pulses + 1;
  end
  always @(negedge sclk) slv_idx <= slv_idx + 3'd1;

  isa_spi_bridge #(.BASE_ADDR(12'h378), .DIV(DIV), .SETTLE_CLKS(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .iow_n(iow_n), .ior_n(ior_n),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .io_rdy(io_rdy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus access with per-cycle measurements
  task automatic access(input logic rd, input logic [11:0] a, input logic [7:0] d,
                        input int extra, input logic corrupt,
                        output logic [7:0] got, output logic oe_seen,
                        output int rdy_low, output int sclk_hi, output int mosi_hi,
                        output int npulse);
    int p0;
    p0 = pulses;
    rdy_low = 0; sclk_hi = 0; mosi_hi = 0;
    @(negedge clk);
    io_addr = a; data_in = d;
    if (rd) ior_n = 1'b0; else iow_n = 1'b0;
    for (int c = 0; c < WIN + extra; c++) begin
      @(negedge clk);
      if (!io_rdy) rdy_low++;
      if (sclk) sclk_hi++;
      if (mosi) mosi_hi++;
      if (corrupt && c == 8) data_in = ~d;
    end
    got = data_out;
    oe_seen = data_oe;
    ior_n = 1'b1; iow_n = 1'b1;
    repeat (6) @(negedge clk);
    npulse = pulses - p0;
  endtask

  task automatic t_reset();
    check("R5 sclk", sclk, 0);
    check("R5 mosi", mosi, 0);
    check("R5 cs_n", cs_n, 1);
    check("R5 io_rdy", io_rdy, 1);
    check("R5 data_oe", data_oe, 0);
  endtask

  task automatic t_select();
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    access(1'b0, 12'h379, 8'hFE, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R4 cs low", cs_n, 0);
    check("R4 no pulses", np, 0);
    access(1'b0, 12'h378, 8'h00, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R4 cs held", cs_n, 0);
    access(1'b0, 12'h379, 8'h01, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R4 cs high", cs_n, 1);
  endtask

  task automatic t_write(input logic [7:0] d);
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    access(1'b0, 12'h378, d, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R2 byte", mon_byte, d);
    check("R2 pulses", np, 8);
    check("R6 sclk high", sh, 8 * DIV);
    check("R6 mosi high", mh, 2 * DIV * $countones(d));
    check("R7 wait write", rl, SETTLE + 24 * DIV + 1);
  endtask

  task automatic t_read(input logic [7:0] s);
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    slave_byte = s;
    access(1'b1, 12'h378, 8'h00, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R3 data", g, s);
    check("R3 dummy", mon_byte, 8'hFF);
    check("R10 oe", oe, 1);
    check("R6 mosi ones", mh, 16 * DIV);
    check("R7 wait read", rl, 24 * DIV + 1);
  endtask

  task automatic t_settle();
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    access(1'b0, 12'h378, 8'h5A, 0, 1'b1, g, oe, rl, sh, mh, np);
    check("R8 captured", mon_byte, 8'h5A);
  endtask

  task automatic t_hold();
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    access(1'b0, 12'h378, 8'hC3, 60, 1'b0, g, oe, rl, sh, mh, np);
    check("R9 one xfer", np, 8);
    check("R9 byte", mon_byte, 8'hC3);
  endtask

  task automatic t_window();
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    access(1'b0, 12'h279, 8'h00, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R1 cs", cs_n, 1);
    check("R1 pulses", np, 0);
    check("R1 rdy", rl, 0);
    access(1'b1, 12'h178, 8'h00, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R1 oe", oe, 0);
    check("R10 no drive", oe, 0);
    check("R1 read pulses", np, 0);
  endtask

  task automatic t_offsets();
    logic [7:0] g; logic oe; int rl, sh, mh, np;
    access(1'b1, 12'h37A, 8'h00, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R11 read pulses", np, 0);
    check("R10 other data", g, 8'hFF);
    check("R10 other oe", oe, 1);
    access(1'b0, 12'h37D, 8'h00, 0, 1'b0, g, oe, rl, sh, mh, np);
    check("R11 write pulses", np, 0);
    check("R11 cs", cs_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_select();
    t_write(8'h3C);
    t_write(8'hA5);
    t_read(8'h96);
    t_read(8'h41);
    t_settle();
    t_hold();
    t_window();
    t_offsets();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule